// File: doc/BRIEF.md
# Command-Processor Microcontroller ALU Slice

This block sits in the execute stage of a small command-processor microcontroller. It takes one 32-bit instruction word plus the two register values the register file has read for it. It decodes the variable-length opcode and its repeat flag, and works out whether the word is an immediate-form or a two-register ALU operation. It then returns the 32-bit result together with the destination register index. The register indices it extracts are also returned, so the surrounding pipeline can address its register file.

The datapath is combinational. The only state is a single carry/borrow bit, which lets a 64-bit add or subtract be done as a low-half operation followed by a high-half operation. The bit is written only on a clock edge where `exec_en` is high and the instruction is one of the four add or subtract operations.

The register file, program counter, branches, loads, stores and control-bus accesses are handled outside this block.

Top module: `mcu_alu_top`

## Requirements
- R1: The header is `instr[31:26]`. When the header is below 0x30, `opcode` is `{1'b0, header[5:1]}` and `rep_flag` is `header[0]`. Otherwise `opcode` is the full header and `rep_flag` is 0.
- R2: `src1_idx` is always `instr[25:21]` and `src2_idx` is always `instr[20:16]`. Opcode 0x13 selects the two-register form: the function is `instr[4:0]`, the second operand is `src2_val`, and `dst_idx` is `instr[15:11]`. For every other opcode, `dst_idx` is `instr[20:16]`. In the immediate form, opcodes 0x01 to 0x11 act as the function and the second operand is `instr[15:0]` zero-extended. The first operand is always `src1_val`.
- R3: Function codes 0x01 add, 0x03 subtract, 0x05 and, 0x06 or and 0x07 xor act on the two operands. Function 0x08 returns the bitwise inverse of the second operand and ignores the first.
- R4: The carry bit resets to 0 (`carry_q`). On a clock edge with `exec_en` high, it is updated by four functions. Add (0x01) stores the carry out of bit 31. Subtract (0x03) stores a borrow, which is 1 when the first operand is unsigned-less than the second. Add-high (0x02) returns a+b+carry and stores its own carry out. Subtract-high (0x04) returns a-b-carry and stores its own borrow. In all other cases the bit holds.
- R5: Functions 0x09 shift left, 0x0a logical shift right, 0x0b arithmetic shift right and 0x0c rotate left use only bits [4:0] of the second operand as the amount.
- R6: Function 0x0d returns the unsigned 16-bit product of bits [7:0] of each operand, zero-extended.
- R7: Function 0x0e returns the unsigned minimum and 0x0f the unsigned maximum. Function 0x10 returns 0 when the operands are equal, 1 when the first is greater and 2 when it is less, all compared unsigned.
- R8: Immediate-form 0x11 returns `instr[15:0]` shifted left by `instr[25:21]`, truncated to 32 bits. Two-register function 0x11 returns `src2_val` unchanged.
- R9: Two-register function 0x14 returns the bit index of the highest set bit of `src2_val`, with 0 returned for an input of 0. Immediate-form opcode 0x14 is not an ALU operation.
- R10: Every word that is not one of the operations above gives `is_alu` = 0 and `result` = 0 and leaves the carry bit unchanged. This covers opcode 0x00, 0x12, 0x14 to 0x2f, any opcode from 0x30 up, and two-register function codes 0x00, 0x12, 0x13 and 0x15 to 0x1f. Every operation above gives `is_alu` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the carry bit |
| exec_en | input | 1 | Instruction executes this cycle; allows the carry update |
| instr | input | 32 | Instruction word |
| src1_val | input | 32 | Value of register `src1_idx` |
| src2_val | input | 32 | Value of register `src2_idx` |
| src1_idx | output | 5 | First source register index |
| src2_idx | output | 5 | Second source register index |
| dst_idx | output | 5 | Destination register index |
| opcode | output | 6 | Decoded opcode |
| rep_flag | output | 1 | Repeat flag |
| is_alu | output | 1 | Word is a supported ALU operation |
| result | output | 32 | ALU result |
| carry_q | output | 1 | Stored carry/borrow bit |

## Verification
The only internal state is the carry bit. A wrong value there shows up on `carry_q` at the next edge. It also shows up on the very next add-high or subtract-high, as a result that is off by exactly one. Corrupted decode state, such as a wrong form select or a wrong function, is visible at once in the same cycle on `result`, `is_alu` or `dst_idx`. The bench therefore checks every combinational output each cycle and follows the carry across chained operations and across idle cycles.

// File: rtl/mcu_alu_pkg.sv
package mcu_alu_pkg;
  localparam int INSTR_W = 32;
  localparam int HDR_W   = 6;
  localparam int FN_W    = 5;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 16;

  localparam logic [HDR_W-1:0] LONG_OPC_MIN = 6'h30;
  localparam logic [HDR_W-1:0] OPC_TWO_REG  = 6'h13;

  localparam logic [FN_W-1:0] FN_ADD   = 5'h01;
  localparam logic [FN_W-1:0] FN_ADDH  = 5'h02;
  localparam logic [FN_W-1:0] FN_SUB   = 5'h03;
  localparam logic [FN_W-1:0] FN_SUBH  = 5'h04;
  localparam logic [FN_W-1:0] FN_AND   = 5'h05;
  localparam logic [FN_W-1:0] FN_OR    = 5'h06;
  localparam logic [FN_W-1:0] FN_XOR   = 5'h07;
  localparam logic [FN_W-1:0] FN_INV   = 5'h08;
  localparam logic [FN_W-1:0] FN_SHL   = 5'h09;
  localparam logic [FN_W-1:0] FN_SHRL  = 5'h0a;
  localparam logic [FN_W-1:0] FN_SHRA  = 5'h0b;
  localparam logic [FN_W-1:0] FN_ROTL  = 5'h0c;
  localparam logic [FN_W-1:0] FN_MUL8  = 5'h0d;
  localparam logic [FN_W-1:0] FN_MIN   = 5'h0e;
  localparam logic [FN_W-1:0] FN_MAX   = 5'h0f;
  localparam logic [FN_W-1:0] FN_CMP   = 5'h10;
  localparam logic [FN_W-1:0] FN_MOV   = 5'h11;
  localparam logic [FN_W-1:0] FN_TOPBIT = 5'h14;

  typedef struct packed {
    logic [HDR_W-1:0]  opcode;
    logic              rep;
    logic              two_reg;
    logic              imm_ok;
    logic [FN_W-1:0]   fn;
    logic [RIDX_W-1:0] src1;
    logic [RIDX_W-1:0] src2;
    logic [RIDX_W-1:0] dst;
    logic [IMM_W-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/mcu_instr_decode.sv
module mcu_instr_decode
  import mcu_alu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  logic [HDR_W-1:0] hdr;
  logic             is_long;

  always_comb begin
    hdr     = instr[INSTR_W-1 -: HDR_W];
    is_long = (hdr >= LONG_OPC_MIN);
    dec     = '0;
    if (is_long) begin
      dec.opcode = hdr;
      dec.rep    = 1'b0;
    end else begin
      dec.opcode = {1'b0, hdr[HDR_W-1:1]};
      dec.rep    = hdr[0];
    end
    dec.two_reg = (dec.opcode == OPC_TWO_REG);
    dec.imm_ok  = !is_long && (dec.opcode >= {1'b0, FN_ADD})
                           && (dec.opcode <= {1'b0, FN_MOV});
    dec.fn      = dec.two_reg ? instr[FN_W-1:0] : dec.opcode[FN_W-1:0];
    dec.src1    = instr[25:21];
    dec.src2    = instr[20:16];
    dec.dst     = dec.two_reg ? instr[15:11] : instr[20:16];
    dec.imm     = instr[IMM_W-1:0];
  end
endmodule

// File: rtl/mcu_msb_index.sv
module mcu_msb_index #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val,
  output logic [IDX_W-1:0]  idx
);
  logic [DATA_W-1:0] top_hit;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      if (gi == DATA_W - 1) begin : g_top
        assign top_hit[gi] = val[gi];
      end else begin : g_low
        assign top_hit[gi] = val[gi] & ~(|val[DATA_W-1:gi+1]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (top_hit[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/mcu_alu_core.sv
module mcu_alu_core
  import mcu_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [FN_W-1:0]   fn,
  input  logic              two_reg,
  input  logic              imm_ok,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [SH_W-1:0]   mov_shift,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res,
  output logic              valid,
  output logic              carry_wr,
  output logic              carry_out
);
  logic [DATA_W:0]    sum_w;
  logic [DATA_W:0]    diff_w;
  logic               cin_eff;
  logic [SH_W-1:0]    amt;
  logic [DATA_W-1:0]  top_idx;
  logic [SH_W-1:0]    top_idx_n;
  logic               op_known;

  mcu_msb_index #(.DATA_W(DATA_W)) u_msb (
    .val (opb),
    .idx (top_idx_n)
  );

  always_comb begin
    top_idx = '0;
    top_idx[SH_W-1:0] = top_idx_n;
    cin_eff = ((fn == FN_ADDH) || (fn == FN_SUBH)) ? carry_in : 1'b0;
    sum_w   = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin_eff};
    diff_w  = {1'b0, opa} - {1'b0, opb} - {{DATA_W{1'b0}}, cin_eff};
    amt     = opb[SH_W-1:0];
  end

  always_comb begin
    res      = '0;
    op_known = 1'b1;
    unique case (fn)
      FN_ADD, FN_ADDH: res = sum_w[DATA_W-1:0];
      FN_SUB, FN_SUBH: res = diff_w[DATA_W-1:0];
      FN_AND:  res = opa & opb;
      FN_OR:   res = opa | opb;
      FN_XOR:  res = opa ^ opb;
      FN_INV:  res = ~opb;
      FN_SHL:  res = opa << amt;
      FN_SHRL: res = opa >> amt;
      FN_SHRA: res = DATA_W'($signed(opa) >>> amt);
      FN_ROTL: res = (opa << amt) | (opa >> (DATA_W - int'(amt)));
      FN_MUL8: res = DATA_W'(opa[7:0] * opb[7:0]);
      FN_MIN:  res = (opa < opb) ? opa : opb;
      FN_MAX:  res = (opa > opb) ? opa : opb;
      FN_CMP:  res = (opa == opb) ? DATA_W'(0) : ((opa > opb) ? DATA_W'(1) : DATA_W'(2));
      FN_MOV:  res = two_reg ? opb : (opb << mov_shift);
      FN_TOPBIT: begin
        if (two_reg) res = top_idx;
        else op_known = 1'b0;
      end
      default: op_known = 1'b0;
    endcase
    valid = op_known && (two_reg || imm_ok);
    if (!valid) res = '0;
  end

  always_comb begin
    carry_wr  = valid && (fn >= FN_ADD) && (fn <= FN_SUBH);
    carry_out = ((fn == FN_ADD) || (fn == FN_ADDH)) ? sum_w[DATA_W] : diff_w[DATA_W];
  end
endmodule

// File: rtl/mcu_alu_top.sv
module mcu_alu_top
  import mcu_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 exec_en,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [DATA_W-1:0]    src1_val,
  input  logic [DATA_W-1:0]    src2_val,
  output logic [RIDX_W-1:0]    src1_idx,
  output logic [RIDX_W-1:0]    src2_idx,
  output logic [RIDX_W-1:0]    dst_idx,
  output logic [HDR_W-1:0]     opcode,
  output logic                 rep_flag,
  output logic                 is_alu,
  output logic [DATA_W-1:0]    result,
  output logic                 carry_q
);
  dec_t              dec;
  logic [DATA_W-1:0] opb;
  logic              carry_wr;
  logic              carry_nx;

  mcu_instr_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  always_comb begin
    opb = '0;
    if (dec.two_reg) opb = src2_val;
    else opb[IMM_W-1:0] = dec.imm;
  end

  mcu_alu_core #(.DATA_W(DATA_W)) u_core (
    .fn        (dec.fn),
    .two_reg   (dec.two_reg),
    .imm_ok    (dec.imm_ok),
    .opa       (src1_val),
    .opb       (opb),
    .mov_shift (SH_W'(dec.src1)),
    .carry_in  (carry_q),
    .res       (result),
    .valid     (is_alu),
    .carry_wr  (carry_wr),
    .carry_out (carry_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else if (exec_en && carry_wr) carry_q <= carry_nx;
  end

  assign src1_idx = dec.src1;
  assign src2_idx = dec.src2;
  assign dst_idx  = dec.dst;
  assign opcode   = dec.opcode;
  assign rep_flag = dec.rep;

  AST_LONG_NO_REP: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] >= LONG_OPC_MIN) |-> (!rep_flag && opcode == instr[31:26])); // R1
  AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !carry_q); // R4
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(exec_en && carry_wr) |-> $stable(carry_q)); // R4
  AST_MUL_NARROW: assert property (@(posedge clk) disable iff (rst)
    (is_alu && dec.fn == FN_MUL8) |-> (result[DATA_W-1:16] == '0)); // R6
  AST_CMP_CODE: assert property (@(posedge clk) disable iff (rst)
    (is_alu && dec.fn == FN_CMP) |-> (result <= DATA_W'(2))); // R7
  AST_TOPBIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (is_alu && dec.fn == FN_TOPBIT && src2_val != '0) |-> ((src2_val >> result) == DATA_W'(1))); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !is_alu |-> (result == '0)); // R10
endmodule

// File: tb/sim_mcu_alu_top.sv
`timescale 1ns/1ps
module sim_mcu_alu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_en = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] src1_val = '0;
  logic [31:0] src2_val = '0;
  logic [4:0]  src1_idx, src2_idx, dst_idx;
  logic [5:0]  opcode;
  logic        rep_flag, is_alu, carry_q;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic model_c = 1'b0;

  always #2.5 clk = ~clk;

  mcu_alu_top u0 (
    .clk(clk), .rst(rst), .exec_en(exec_en), .instr(instr),
    .src1_val(src1_val), .src2_val(src2_val),
    .src1_idx(src1_idx), .src2_idx(src2_idx), .dst_idx(dst_idx),
    .opcode(opcode), .rep_flag(rep_flag), .is_alu(is_alu),
    .result(result), .carry_q(carry_q)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s instr=%08h actual=%08h expected=%08h", tag, instr, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  function automatic string tag_of(input logic [4:0] fn);
    case (fn)
      5'h01, 5'h02, 5'h03, 5'h04: return "R4";
      5'h05, 5'h06, 5'h07, 5'h08: return "R3";
      5'h09, 5'h0a, 5'h0b, 5'h0c: return "R5";
      5'h0d: return "R6";
      5'h0e, 5'h0f, 5'h10: return "R7";
      5'h11: return "R8";
      5'h14: return "R9";
      default: return "R10";
    endcase
  endfunction

  // reference model: all outputs from the requirements
  task automatic model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] r2,
                       input logic cin,
                       output logic [5:0] e_op, output logic e_rep, output logic [4:0] e_dst,
                       output logic e_alu, output logic [31:0] e_res,
                       output logic e_cwr, output logic e_cnew, output logic [4:0] e_fn);
    logic [5:0]  h;
    logic        two;
    logic [31:0] b;
    logic [32:0] wide;
    logic [4:0]  s;
    h = w[31:26];
    if (h < 6'h30) begin e_op = {1'b0, h[5:1]}; e_rep = h[0]; end
    else begin e_op = h; e_rep = 1'b0; end
    two   = (e_op == 6'h13);
    e_dst = two ? w[15:11] : w[20:16];
    e_fn  = two ? w[4:0] : e_op[4:0];
    b     = two ? r2 : {16'h0, w[15:0]};
    s     = b[4:0];
    e_alu = 1'b1; e_res = '0; e_cwr = 1'b0; e_cnew = 1'b0;
    if (!two && !(e_op >= 6'h01 && e_op <= 6'h11)) e_alu = 1'b0;
    else begin
      case (e_fn)
        5'h01: begin wide = {1'b0,a} + {1'b0,b}; e_res = wide[31:0]; e_cwr = 1; e_cnew = wide[32]; end
        5'h02: begin wide = {1'b0,a} + {1'b0,b} + 33'(cin); e_res = wide[31:0]; e_cwr = 1; e_cnew = wide[32]; end
        5'h03: begin e_res = a - b; e_cwr = 1; e_cnew = (a < b); end
        5'h04: begin e_res = a - b - 32'(cin); e_cwr = 1; e_cnew = ({1'b0,a} < ({1'b0,b} + 33'(cin))); end
        5'h05: e_res = a & b;
        5'h06: e_res = a | b;
        5'h07: e_res = a ^ b;
        5'h08: e_res = ~b;
        5'h09: e_res = a << s;
        5'h0a: e_res = a >> s;
        5'h0b: begin e_res = a; for (int i = 0; i < 32; i++) if (i < s) e_res = {e_res[31], e_res[31:1]}; end
        5'h0c: begin e_res = a; for (int i = 0; i < 32; i++) if (i < s) e_res = {e_res[30:0], e_res[31]}; end
        5'h0d: e_res = {16'h0, 8'h0 + a[7:0] * 16'h1 * b[7:0]};
        5'h0e: e_res = (a < b) ? a : b;
        5'h0f: e_res = (a > b) ? a : b;
        5'h10: e_res = (a == b) ? 0 : ((a > b) ? 1 : 2);
        5'h11: e_res = two ? b : (b << w[25:21]);
        5'h14: begin
          if (two) begin for (int i = 0; i < 32; i++) if (b[i]) e_res = i; end
          else e_alu = 1'b0;
        end
        default: e_alu = 1'b0;
      endcase
    end
    if (!e_alu) begin e_res = '0; e_cwr = 1'b0; end
  endtask

  task automatic step(input logic [31:0] w, input logic [31:0] a, input logic [31:0] r2, input logic en);
    logic [5:0] e_op; logic e_rep; logic [4:0] e_dst; logic e_alu;
    logic [31:0] e_res; logic e_cwr; logic e_cnew; logic [4:0] e_fn;
    @(negedge clk);
    instr = w; src1_val = a; src2_val = r2; exec_en = en;
    #1;
    model(w, a, r2, model_c, e_op, e_rep, e_dst, e_alu, e_res, e_cwr, e_cnew, e_fn);
    check("R1 opcode", 32'(opcode), 32'(e_op));
    check("R1 rep", 32'(rep_flag), 32'(e_rep));
    check("R2 dst", 32'(dst_idx), 32'(e_dst));
    check("R2 srcidx", {22'h0, src1_idx, src2_idx}, {22'h0, w[25:21], w[20:16]});
    check({tag_of(e_fn), " valid"}, 32'(is_alu), 32'(e_alu));
    check({e_alu ? tag_of(e_fn) : "R10", " result"}, result, e_res);
    check("R4 carry", 32'(carry_q), 32'(model_c));
    @(posedge clk);
    if (en && e_cwr) model_c = e_cnew;
  endtask

  function automatic logic [31:0] imm_w(input logic [4:0] op, input logic rep,
                                        input logic [4:0] s, input logic [4:0] d, input logic [15:0] im);
    return {op, rep, s, d, im};
  endfunction

  function automatic logic [31:0] reg_w(input logic [4:0] fn, input logic [4:0] s1,
                                        input logic [4:0] s2, input logic [4:0] d);
    return {6'h26, s1, s2, d, 2'b01, 4'h0, fn};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 reset carry", 32'(carry_q), 32'h0);
    rst = 1'b0;
    // directed corners
    step(imm_w(5'h01, 1'b1, 5'd2, 5'd3, 16'h0001), 32'hFFFF_FFFF, 0, 1);      // R4 add carries
    step(imm_w(5'h01, 1'b0, 5'd2, 5'd3, 16'h0000), 32'h0, 0, 0);              // idle: carry holds
    step(imm_w(5'h02, 1'b0, 5'd2, 5'd4, 16'h0000), 32'h0, 0, 1);              // R4 addhi adds 1
    step(imm_w(5'h03, 1'b0, 5'd1, 5'd4, 16'h0001), 32'h0, 0, 1);              // R4 borrow
    step(imm_w(5'h04, 1'b0, 5'd1, 5'd4, 16'h0000), 32'h5, 0, 1);              // R4 subhi 5-0-1
    step(imm_w(5'h04, 1'b0, 5'd1, 5'd4, 16'h0000), 32'h0, 0, 1);              // R4 subhi borrow chain
    step(reg_w(5'h14, 1, 2, 7), 32'h1234, 32'h0, 1);                          // R9 zero input
    step(reg_w(5'h14, 1, 2, 7), 32'h0, 32'h1, 1);                             // R9 one
    step(reg_w(5'h14, 1, 2, 7), 32'h0, 32'h8000_0000, 1);                     // R9 top bit
    step(imm_w(5'h14, 1'b0, 5'd1, 5'd2, 16'hFFFF), 32'h7, 0, 1);              // R9 imm form not ALU
    step({6'h3f, 26'h3FF_FFFF}, 32'h1, 32'h1, 1);                             // R1 long header, R10
    step({6'h36, 26'h0}, 32'h1, 32'h1, 1);                                    // R1
    step(imm_w(5'h10, 1'b0, 5'd1, 5'd2, 16'h0009), 32'h9, 0, 1);              // R7 eq
    step(imm_w(5'h10, 1'b0, 5'd1, 5'd2, 16'h0009), 32'hA, 0, 1);              // R7 gt
    step(imm_w(5'h10, 1'b0, 5'd1, 5'd2, 16'h0009), 32'h8, 0, 1);              // R7 lt
    step(imm_w(5'h0c, 1'b0, 5'd1, 5'd2, 16'h0020), 32'h8000_0001, 0, 1);      // R5 amount 32 -> 0
    step(imm_w(5'h0b, 1'b0, 5'd1, 5'd2, 16'h0004), 32'h8000_0000, 0, 1);      // R5 arithmetic
    step(imm_w(5'h11, 1'b0, 5'd31, 5'd2, 16'h0003), 32'h0, 0, 1);             // R8 shift 31
    step(reg_w(5'h11, 31, 2, 9), 32'h0, 32'hCAFE_F00D, 1);                    // R8 reg move
    step(imm_w(5'h08, 1'b0, 5'd1, 5'd2, 16'h00F0), 32'hDEAD_BEEF, 0, 1);      // R3 inverse
    step(imm_w(5'h0d, 1'b0, 5'd1, 5'd2, 16'h12FF), 32'hFFFF_FFFF, 0, 1);      // R6
    step(reg_w(5'h13, 1, 2, 3), 32'h5, 32'h5, 1);                             // R10 bad fn
    step(imm_w(5'h00, 1'b1, 5'd1, 5'd2, 16'h1), 32'h5, 32'h5, 1);             // R10 nop
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w;
      logic [31:0] a;
      logic [31:0] r2;
      int k;
      k = $urandom_range(0, 9);
      w = $urandom;
      if (k < 4) w[31:26] = {$urandom_range(1, 17) % 32, w[26]} ;
      else if (k < 8) w[31:27] = 5'h13;
      a  = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 40)) : $urandom;
      r2 = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      step(w, a, r2, $urandom_range(0, 3) != 0);
    end
    finish_run();
  end
endmodule